// File: doc/BRIEF.md
# Half-Duplex Bus Transmitter with Hardware Driver-Enable Control

This block serialises bytes onto a shared half-duplex differential bus and drives the line-driver enable itself. Software never has to time the release of the bus. A byte written into a single-entry holding stage is moved into a shift register. It leaves the block as one start bit (low), eight data bits with the least significant bit first, and one stop bit (high). Each bit lasts a programmable number of clock cycles. The driver enable rises together with the start bit. It falls only after the whole stop bit of the last queued byte has been driven.

Two events are reported, each as a one-cycle pulse and as a sticky flag that a write-one strobe clears. The holding-empty event fires when a byte moves from the holding stage into the shift register. The transmission-complete event fires once the final stop bit has left the shifter. When another node has just finished talking, a receive-end pulse arms a turnaround delay of N idle characters. These characters are timed by the same bit machinery with the driver off and the line high, before the next frame may start. A preamble of 0xFF bytes needs no special handling: on the wire each one is a single low start bit.

Top module: `rs485_tx_ctrl`

## Requirements
- R1: After reset, drv_en is 0, txd is 1, wr_ready is 1, and both sticky flags and both pulses are 0.
- R2: A frame is start bit 0, then wr_data[0] through wr_data[7], then stop bit 1. Each bit lasts baud_div cycles, and a baud_div of 0 acts as 1. txd is 1 whenever drv_en is 0. A 0xFF byte therefore shows as exactly one low bit time.
- R3: With no turnaround armed, drv_en first reads 1 in the second cycle after the edge that accepts a write into an idle block. It stays 1 for exactly 10*baud_div*k cycles for k bytes sent back to back, and it falls only after the full stop bit of the last byte.
- R4: hre_pulse is a one-cycle pulse in the first cycle of each start bit, when that byte has moved into the shifter. wr_ready reads 1 in that same cycle.
- R5: tc_pulse is a one-cycle pulse in the first cycle in which drv_en is 0 again after a burst. It does not fire between back-to-back bytes.
- R6: hre_flag and tc_flag become 1 in the cycle after their pulse and hold until a one-cycle clr_hre or clr_tc strobe, which clears them at the next edge.
- R7: A write while wr_ready is 0 is ignored. The queued byte is not overwritten, and no extra byte is sent.
- R8: A rx_end pulse loads turn_chars as the number of pending idle characters. The next frame then starts 10*turn_chars*baud_div cycles later than in R3, with drv_en 0 and txd 1 during the delay. The delay is consumed once. A turn_chars of 0 adds no delay.
- R9: A rx_end pulse that arrives during a turnaround delay restarts the full delay from the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_div | input | 16 | Clock cycles per bit; 0 acts as 1; change only while idle |
| turn_chars | input | 4 | Idle characters inserted after a receive-end pulse |
| rx_end | input | 1 | One-cycle pulse: the last received character on the bus just ended |
| wr_valid | input | 1 | Write strobe for the holding stage |
| wr_data | input | 8 | Byte to transmit |
| wr_ready | output | 1 | Holding stage is empty and accepts a write |
| clr_hre | input | 1 | Write-one clear of hre_flag |
| clr_tc | input | 1 | Write-one clear of tc_flag |
| txd | output | 1 | Serial data to the line driver, high when idle |
| drv_en | output | 1 | Line-driver enable |
| hre_pulse | output | 1 | Holding-empty event pulse |
| tc_pulse | output | 1 | Transmission-complete event pulse |
| hre_flag | output | 1 | Sticky holding-empty status |
| tc_flag | output | 1 | Sticky transmission-complete status |

## Verification
The bench sweeps every byte value at the shortest bit time. It also sends back-to-back bursts across several divisors, including 0. It checks every cycle of txd against an arithmetic model and times the whole drv_en window. A design that drops the enable at the start of the stop bit shows a window that is short by one bit time. A design that fires tc between queued bytes or misplaces hre is caught by the pulse checks. The turnaround cases measure the start latency for zero and non-zero counts, for a second frame that must not be delayed again, and for a restart in mid-delay. A counter that is off by one character or never consumed shows up as a shifted start.

// File: rtl/rs485_tx_pkg.sv
// Shared types for the half-duplex transmitter.
// Assumes nothing beyond a single clock domain.
package rs485_tx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_SEND = 2'd2
    } tx_state_e;
endpackage

// File: rtl/rs485_bit_timer.sv
// Bit and character timer. It counts clock cycles per bit and bits per
// character while run is high, and it produces bit_end and char_end strobes.
// Assumes div is stable while run is high. A div of 0 behaves as 1.
module rs485_bit_timer #(
    parameter int DIV_W      = 16,
    parameter int FRAME_BITS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             bit_end,
    output logic             char_end
);
    localparam int IDX_W = $clog2(FRAME_BITS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    logic [DIV_W-1:0] div_eff;
    logic [DIV_W-1:0] cyc_cnt;
    logic [IDX_W-1:0] bit_idx;

    // Effective divisor with 0 mapped to 1.
    always_comb div_eff = (div == '0) ? DIV_W'(1) : div;

    assign bit_end  = run && (cyc_cnt == div_eff - DIV_W'(1));
    assign char_end = bit_end && (bit_idx == LAST_IDX);

    // Cycle and bit counters, held at zero while stopped or restarted.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            cyc_cnt <= '0;
            bit_idx <= '0;
        end else if (bit_end) begin
            cyc_cnt <= '0;
            bit_idx <= (bit_idx == LAST_IDX) ? '0 : bit_idx + IDX_W'(1);
        end else begin
            cyc_cnt <= cyc_cnt + DIV_W'(1);
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cyc_cnt < div_eff)); // R2
endmodule

// File: rtl/rs485_event_flag.sv
// Sticky status bit. It is set by an event pulse and cleared by a
// write-one strobe, and the set wins over the clear.
// Assumes both inputs are synchronous one-cycle strobes.
module rs485_event_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse,
    input  logic clear,
    output logic flag
);
    // Set on event, clear on strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag <= 1'b0;
        else if (pulse) flag <= 1'b1;
        else if (clear) flag <= 1'b0;
    end

    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> flag); // R6
endmodule

// File: rtl/rs485_tx_ctrl.sv
// Half-duplex serial transmitter with hardware line-driver enable.
// A one-entry holding stage feeds a shift register that sends 8N1 frames.
// drv_en covers start to end of stop bit of the last queued byte. A
// receive-end pulse arms a turnaround delay of idle characters.
// Assumes baud_div and turn_chars change only while the block is idle.
module rs485_tx_ctrl
    import rs485_tx_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int TURN_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic [TURN_W-1:0] turn_chars,
    input  logic              rx_end,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              clr_hre,
    input  logic              clr_tc,
    output logic              txd,
    output logic              drv_en,
    output logic              hre_pulse,
    output logic              tc_pulse,
    output logic              hre_flag,
    output logic              tc_flag
);
    localparam int FRAME_BITS = DATA_W + 2;
    localparam int NUM_EVT    = 2;

    tx_state_e           state, state_nx;
    logic                hold_full;
    logic [DATA_W-1:0]   hold_data;
    logic [FRAME_BITS-1:0] shreg;
    logic [TURN_W-1:0]   pend;
    logic                load, tc_go;
    logic                bit_end, char_end;
    logic [NUM_EVT-1:0]  evt_pulse, evt_clear, evt_flag;

    rs485_bit_timer #(.DIV_W(DIV_W), .FRAME_BITS(FRAME_BITS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state != ST_IDLE),
        .restart  (rx_end && (state == ST_WAIT)),
        .div      (baud_div),
        .bit_end  (bit_end),
        .char_end (char_end)
    );

    // Next-state and load decision.
    always_comb begin
        state_nx = state;
        load     = 1'b0;
        tc_go    = 1'b0;
        unique case (state)
            ST_IDLE: if (hold_full) begin
                if (pend != '0) state_nx = ST_WAIT;
                else begin state_nx = ST_SEND; load = 1'b1; end
            end
            ST_WAIT: if (!rx_end && ((pend == '0) ||
                                     (char_end && pend == TURN_W'(1)))) begin
                state_nx = ST_SEND;
                load     = 1'b1;
            end
            ST_SEND: if (char_end) begin
                if (hold_full) load = 1'b1;
                else begin state_nx = ST_IDLE; tc_go = 1'b1; end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            hre_pulse <= 1'b0;
            tc_pulse  <= 1'b0;
        end else begin
            state     <= state_nx;
            hre_pulse <= load;
            tc_pulse  <= tc_go;
        end
    end

    // Holding stage: accepts a write only when empty, empties on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
            hold_data <= '0;
        end else if (load) begin
            hold_full <= 1'b0;
        end else if (wr_valid && !hold_full) begin
            hold_full <= 1'b1;
            hold_data <= wr_data;
        end
    end

    // Pending turnaround characters: armed by rx_end, consumed in WAIT.
    always_ff @(posedge clk) begin
        if (!rst_n)                          pend <= '0;
        else if (rx_end)                     pend <= turn_chars;
        else if (state == ST_WAIT && char_end) pend <= pend - TURN_W'(1);
    end

    // Shift register: frame loaded LSB-side first, shifted at each bit end.
    always_ff @(posedge clk) begin
        if (!rst_n)                           shreg <= '1;
        else if (load)                        shreg <= {1'b1, hold_data, 1'b0};
        else if (state == ST_SEND && bit_end) shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
    end

    assign drv_en   = (state == ST_SEND);
    assign txd      = drv_en ? shreg[0] : 1'b1;
    assign wr_ready = !hold_full;

    assign evt_pulse = {tc_pulse, hre_pulse};
    assign evt_clear = {clr_tc, clr_hre};

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_flag
        rs485_event_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .pulse (evt_pulse[g]),
            .clear (evt_clear[g]),
            .flag  (evt_flag[g])
        );
    end

    assign hre_flag = evt_flag[0];
    assign tc_flag  = evt_flag[1];

    AST_HRE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        hre_pulse |-> (drv_en && !txd)); // R4
    AST_TC_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_en) |-> tc_pulse); // R5
    AST_TC_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> !drv_en); // R5
    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_full && wr_valid) |=> $stable(hold_data)); // R7
endmodule

// File: tb/rs485_tx_ctrl_tb.sv
module rs485_tx_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] baud_div = 16'd1;
    logic [3:0]  turn_chars = 4'd0;
    logic        rx_end = 1'b0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        clr_hre = 1'b0, clr_tc = 1'b0;
    logic        wr_ready, txd, drv_en, hre_pulse, tc_pulse, hre_flag, tc_flag;

    int n_chk = 0, n_fail = 0, cycles = 0;
    bit done = 0;

    logic [7:0] exp_bytes [16];
    int exp_cnt = 0;
    int mon_cyc = 0;
    logic prev_drv = 1'b0;
    int hre_seen = 0, tc_seen = 0;

    always #2.5 clk = ~clk;

    rs485_tx_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .turn_chars(turn_chars),
        .rx_end(rx_end), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .clr_hre(clr_hre), .clr_tc(clr_tc), .txd(txd), .drv_en(drv_en),
        .hre_pulse(hre_pulse), .tc_pulse(tc_pulse), .hre_flag(hre_flag), .tc_flag(tc_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int deff();
        return (baud_div == 16'd0) ? 1 : int'(baud_div);
    endfunction

    // Per-cycle wire model: txd against the expected frames, window length.
    always @(negedge clk) begin
        if (rst_n) begin
            if (hre_pulse) hre_seen++;
            if (tc_pulse)  tc_seen++;
            if (drv_en) begin
                int d, bi, bb, e;
                if (!prev_drv) mon_cyc = 0;
                d  = deff();
                bb = mon_cyc / (10 * d);
                bi = (mon_cyc / d) % 10;
                if (bi == 0)      e = 0;
                else if (bi == 9) e = 1;
                else              e = int'(exp_bytes[bb % 16][bi-1]);
                chk(int'(txd) == e, "R2 txd bit", int'(txd), e);
                mon_cyc++;
            end else begin
                chk(txd == 1'b1, "R2 txd idle high", int'(txd), 1);
                if (prev_drv)
                    chk(mon_cyc == 10 * deff() * exp_cnt, "R3 drv_en window",
                        mon_cyc, 10 * deff() * exp_cnt);
            end
            prev_drv = drv_en;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Waits for wr_ready, then writes one byte.
    task automatic put(input logic [7:0] b);
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        wr_valid = 1'b1; wr_data = b;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // Writes without waiting for wr_ready.
    task automatic poke(input logic [7:0] b);
        wr_valid = 1'b1; wr_data = b;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (drv_en || !wr_ready) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Write into an idle block and return the cycles until drv_en reads 1.
    task automatic put_lat(input logic [7:0] b, input int restart_at, output int lat);
        @(negedge clk);
        wr_valid = 1'b1; wr_data = b;
        @(negedge clk);
        wr_valid = 1'b0;
        lat = 0;
        while (!drv_en && lat < 5000) begin
            if (lat == restart_at) rx_end = 1'b1;
            @(negedge clk);
            rx_end = 1'b0;
            lat++;
        end
    endtask

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        chk(drv_en == 0, "R1 drv_en reset", int'(drv_en), 0);
        chk(txd == 1, "R1 txd reset", int'(txd), 1);
        chk(wr_ready == 1, "R1 wr_ready reset", int'(wr_ready), 1);
        chk({hre_flag, tc_flag, hre_pulse, tc_pulse} == 4'b0, "R1 status reset",
            int'({hre_flag, tc_flag, hre_pulse, tc_pulse}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R3: every byte value at one cycle per bit.
        baud_div = 16'd1;
        for (int v = 0; v < 256; v++) begin
            exp_bytes[0] = 8'(v); exp_cnt = 1;
            put(8'(v));
            wait_idle();
        end

        // R2/R3/R4/R5: bursts of three over several divisors, 0 included.
        for (int d = 0; d < 5; d++) begin
            int h0, t0;
            baud_div = 16'(d);
            exp_bytes[0] = 8'hFF; exp_bytes[1] = 8'h55; exp_bytes[2] = 8'h00;
            exp_cnt = 3;
            h0 = hre_seen; t0 = tc_seen;
            put_lat(8'hFF, -1, lat);
            chk(lat == 1, "R3 start latency", lat, 1);
            chk(hre_pulse == 1 && wr_ready == 1, "R4 hre at start bit",
                int'({hre_pulse, wr_ready}), 3);
            put(8'h55);
            put(8'h00);
            @(negedge clk);
            while (drv_en) @(negedge clk);
            chk(tc_pulse == 1, "R5 tc on first idle cycle", int'(tc_pulse), 1);
            @(negedge clk);
            chk(tc_pulse == 0, "R5 tc one cycle", int'(tc_pulse), 0);
            chk(hre_seen - h0 == 3, "R4 hre count", hre_seen - h0, 3);
            chk(tc_seen - t0 == 1, "R5 tc once per burst", tc_seen - t0, 1);
            chk(tc_flag == 1 && hre_flag == 1, "R6 flags set",
                int'({tc_flag, hre_flag}), 3);
            clr_tc = 1'b1; @(negedge clk); clr_tc = 1'b0;
            chk(tc_flag == 0 && hre_flag == 1, "R6 tc clear only",
                int'({tc_flag, hre_flag}), 1);
            clr_hre = 1'b1; @(negedge clk); clr_hre = 1'b0;
            chk(hre_flag == 0, "R6 hre clear", int'(hre_flag), 0);
            wait_idle();
        end

        // R7: a write while the holding stage is full is dropped.
        baud_div = 16'd3;
        exp_bytes[0] = 8'hA5; exp_bytes[1] = 8'h3C; exp_cnt = 2;
        put(8'hA5);
        put(8'h3C);
        chk(wr_ready == 0, "R7 holding full", int'(wr_ready), 0);
        poke(8'hC3);
        wait_idle();
        chk(mon_cyc == 60, "R7 only two bytes sent", mon_cyc, 60);

        // R8: turnaround delays of several lengths, consumed once.
        for (int n = 0; n < 4; n++) begin
            baud_div = 16'd2; turn_chars = 4'(n);
            @(negedge clk); rx_end = 1'b1; @(negedge clk); rx_end = 1'b0;
            exp_bytes[0] = 8'h81; exp_cnt = 1;
            put_lat(8'h81, -1, lat);
            chk(lat == 1 + 20 * n, "R8 turnaround latency", lat, 1 + 20 * n);
            wait_idle();
            put_lat(8'h81, -1, lat);
            chk(lat == 1, "R8 delay consumed once", lat, 1);
            wait_idle();
        end

        // R9: rx_end in the middle of the delay restarts it.
        baud_div = 16'd2; turn_chars = 4'd2;
        @(negedge clk); rx_end = 1'b1; @(negedge clk); rx_end = 1'b0;
        exp_bytes[0] = 8'h7E; exp_cnt = 1;
        put_lat(8'h7E, 25, lat);
        chk(lat == 26 + 40, "R9 restart latency", lat, 66);
        wait_idle();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule